// File: doc/BRIEF.md
# DMA channel start-request controller

This block sits in front of a small two-channel DMA transfer engine and decides when each channel starts a transfer. Each channel has an 8-bit mode register. Its fields choose the transfer direction and the data width. A hold bit parks start requests. A 4-bit field picks which of sixteen hardware request lines starts the channel. A write-only trigger bit starts a transfer from software. Requests come from a rising edge on the selected hardware line or from a trigger write. They are taken only while the channel's enable input is high.

A taken request either goes straight to launch or, when the hold is in force, waits in a single-entry parked flag. Clearing the hold bit releases it. Setting the hold bit does not take effect at once: requests that arrive in the two clocks after the write still launch. Launched transfers leave through a valid/ready port to the transfer datapath. The channel number, direction and width are registered together with `xfer_valid`. They stay frozen while `xfer_ready` is low. A transfer is accepted on the clock edge where both signals are high. No new transfer is presented in the cycle that follows a handshake. There is no other back-pressure: requests that arrive while the port is stalled collect in the per-channel flags.

Top module: `dma_start_ctrl`

## Requirements
- R1: After reset, both mode registers read 0x00 and `xfer_valid` is low.
- R2: Mode bits are: 7 = software trigger, 6 = direction, 5 = width, 4 = hold, 3..0 = hardware source select. Reading a channel returns bits 6..0 as last written, and bit 7 always reads 0.
- R3: A configuration write with bit 7 set, to a channel whose enable is 1, starts exactly one transfer, whatever the source select holds. `xfer_valid` rises two clocks after the write cycle. With enable 0 the trigger does nothing.
- R4: A rising edge on `hw_req[src]` of an enabled channel starts exactly one transfer, with the same two-clock latency. A line held high does not start another. Lines other than the selected one, and any line of a disabled channel, start nothing.
- R5: `xfer_dir` carries mode bit 6: 0 means peripheral register to internal RAM, 1 means internal RAM to peripheral register. `xfer_size` carries bit 5: 0 means 8-bit, 1 means 16-bit. `xfer_ch` is the channel index.
- R6: After a write that sets the hold bit, requests arriving in the first or second clock after the write cycle still launch. Requests from the third clock on are parked.
- R7: Clearing the hold bit releases a parked request. `xfer_valid` rises three clocks after the clearing write cycle.
- R8: Each channel keeps one pending request. Requests that coincide in one cycle, or arrive while one is parked or waiting, merge and produce a single transfer.
- R9: While `ch_active` of a channel is 1, a write to it changes only the hold bit (and may trigger). Bits 6, 5 and 3..0 keep their values.
- R10: When both channels are ready to launch in the same cycle, channel 0 is presented first. Channel 1 is presented in the second cycle after channel 0's handshake.
- R11: While `xfer_valid` is high and `xfer_ready` is low, the valid signal and the transfer attributes hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_wdata | input | 8 | Write data (bit layout in R2) |
| rd_ch | input | 1 | Channel selected for read-back |
| rd_data | output | 8 | Read-back of the selected mode register |
| ch_enable | input | 2 | Per-channel enable; requests are ignored when 0 |
| ch_active | input | 2 | Per-channel busy status from the datapath; write-protects fields |
| hw_req | input | 16 | Hardware start request lines |
| xfer_valid | output | 1 | Transfer start is being presented |
| xfer_ready | input | 1 | Datapath accepts the presented transfer |
| xfer_ch | output | 1 | Channel of the presented transfer |
| xfer_dir | output | 1 | Direction of the presented transfer |
| xfer_size | output | 1 | Width of the presented transfer |

## Verification
Two start sources can land on one channel in the same clock: a trigger write and a rising edge on the selected hardware line. The bench drives both on the same edge and also raises one line shared by both channels. It judges the result by counting presented transfers. It expects exactly one for the merged channel. For the shared line it expects channel 0 first and channel 1 only after the stalled handshake completes. A second collision, a hold-bit write overlapping arriving requests, is driven in the first, second and third clock after the write, to pin the exact edge where parking begins.

// File: rtl/dma_sc_pkg.sv
package dma_sc_pkg;
  localparam int MODE_W   = 8;
  localparam int SRC_W    = 4;
  localparam int TRIG_BIT = 7;
  localparam int DIR_BIT  = 6;
  localparam int SIZE_BIT = 5;
  localparam int HOLD_BIT = 4;

  typedef enum logic { DIR_PER_TO_RAM = 1'b0, DIR_RAM_TO_PER = 1'b1 } dir_e;
  typedef enum logic { SIZE_BYTE = 1'b0, SIZE_HALF = 1'b1 } size_e;

  typedef struct packed {
    dir_e             dir;
    size_e            size;
    logic             hold;
    logic [SRC_W-1:0] src;
  } mode_t;
endpackage

// File: rtl/dma_mode_reg.sv
module dma_mode_reg
  import dma_sc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [MODE_W-1:0] wr_data,
  input  logic              active,
  input  logic              enable,
  output mode_t             mode,
  output logic              sw_start
);
  // trigger is never stored; it acts only in the write cycle
  assign sw_start = wr_hit & wr_data[TRIG_BIT] & enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (wr_hit) begin
      mode.hold <= wr_data[HOLD_BIT];
      if (!active) begin
        mode.dir  <= dir_e'(wr_data[DIR_BIT]);
        mode.size <= size_e'(wr_data[SIZE_BIT]);
        mode.src  <= wr_data[SRC_W-1:0];
      end
    end
  end

  // R9: protected fields keep their value across a write while busy
  a_r9_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && active) |=> (mode.dir == $past(mode.dir)) &&
                           (mode.size == $past(mode.size)) &&
                           (mode.src == $past(mode.src)));
endmodule

// File: rtl/dma_req_track.sv
module dma_req_track #(
  parameter int NSRC     = 16,
  parameter int SELW     = 4,
  parameter int HOLD_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hw_req,
  input  logic [SELW-1:0] src,
  input  logic            hold,
  input  logic            enable,
  input  logic            sw_start,
  input  logic            grant,
  output logic            go
);
  logic [NSRC-1:0]     req_q;
  logic [NSRC-1:0]     rise;
  logic [HOLD_LAT-1:0] hold_sh;
  logic                hold_eff;
  logic                hw_start;
  logic                start;
  logic                park, park_n, go_n;

  assign rise     = hw_req & ~req_q;
  assign hw_start = enable & rise[src];
  assign start    = hw_start | sw_start;
  // hold only bites once it has aged HOLD_LAT clocks; clearing acts at once
  assign hold_eff = hold & hold_sh[HOLD_LAT-1];

  generate
    if (HOLD_LAT == 1) begin : g_sh1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) hold_sh <= '0;
        else        hold_sh <= hold;
    end else begin : g_shn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) hold_sh <= '0;
        else        hold_sh <= {hold_sh[HOLD_LAT-2:0], hold};
    end
  endgenerate

  always_comb begin
    go_n   = go & ~grant;
    park_n = park;
    if (start) begin
      if (hold_eff) park_n = 1'b1;
      else          go_n   = 1'b1;
    end
    if (park && !hold) begin
      park_n = 1'b0;
      go_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      park  <= 1'b0;
      go    <= 1'b0;
    end else begin
      req_q <= hw_req;
      park  <= park_n;
      go    <= go_n;
    end
  end

  // R6: a request meeting an aged hold is parked, not launched
  a_r6_park: assert property (@(posedge clk) disable iff (!rst_n)
    (start && hold_eff) |=> park);
  // R7: dropping the hold moves the parked request to launch
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (park && !hold) |=> (go && !park));
  // R8: a granted channel with no new request falls idle
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !start && !park) |=> !go);
endmodule

// File: rtl/dma_launch_arb.sv
module dma_launch_arb #(
  parameter int NCH  = 2,
  parameter int CHW  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  go,
  input  logic [NCH-1:0]  ch_dir,
  input  logic [NCH-1:0]  ch_size,
  output logic [NCH-1:0]  grant,
  output logic            xfer_valid,
  input  logic            xfer_ready,
  output logic [CHW-1:0]  xfer_ch,
  output logic            xfer_dir,
  output logic            xfer_size
);
  logic [CHW-1:0] pick;
  logic           any;
  logic           load;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (go[i]) begin
        pick = CHW'(i);
        any  = 1'b1;
      end
    end
  end

  assign load = any & ~xfer_valid;

  always_comb begin
    for (int i = 0; i < NCH; i++) grant[i] = load && (pick == CHW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_valid <= 1'b0;
      xfer_ch    <= '0;
      xfer_dir   <= 1'b0;
      xfer_size  <= 1'b0;
    end else if (load) begin
      xfer_valid <= 1'b1;
      xfer_ch    <= pick;
      xfer_dir   <= ch_dir[pick];
      xfer_size  <= ch_size[pick];
    end else if (xfer_valid && xfer_ready) begin
      xfer_valid <= 1'b0;
    end
  end

  // R10: at most one channel granted per cycle
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R10: channel 0 wins when the port is free
  a_r10_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_valid && go[0]) |=> (xfer_valid && xfer_ch == '0));
  // R11: presented transfer holds still under back-pressure
  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_ch) &&
                                     $stable(xfer_dir) && $stable(xfer_size)));
endmodule

// File: rtl/dma_start_ctrl.sv
module dma_start_ctrl
  import dma_sc_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int HOLD_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [MODE_W-1:0]     cfg_wdata,
  input  logic [$clog2(NCH)-1:0] rd_ch,
  output logic [MODE_W-1:0]     rd_data,
  input  logic [NCH-1:0]        ch_enable,
  input  logic [NCH-1:0]        ch_active,
  input  logic [(1<<SRC_W)-1:0] hw_req,
  output logic                  xfer_valid,
  input  logic                  xfer_ready,
  output logic [$clog2(NCH)-1:0] xfer_ch,
  output logic                  xfer_dir,
  output logic                  xfer_size
);
  localparam int CHW  = $clog2(NCH);
  localparam int NSRC = 1 << SRC_W;

  mode_t          mode [NCH];
  logic [NCH-1:0] sw_start, go, grant, dir_v, size_v;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      dma_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (cfg_wr && (cfg_ch == CHW'(c))),
        .wr_data  (cfg_wdata),
        .active   (ch_active[c]),
        .enable   (ch_enable[c]),
        .mode     (mode[c]),
        .sw_start (sw_start[c])
      );

      dma_req_track #(.NSRC(NSRC), .SELW(SRC_W), .HOLD_LAT(HOLD_LAT)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_req   (hw_req),
        .src      (mode[c].src),
        .hold     (mode[c].hold),
        .enable   (ch_enable[c]),
        .sw_start (sw_start[c]),
        .grant    (grant[c]),
        .go       (go[c])
      );

      assign dir_v[c]  = mode[c].dir;
      assign size_v[c] = mode[c].size;
    end
  endgenerate

  dma_launch_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .ch_dir     (dir_v),
    .ch_size    (size_v),
    .grant      (grant),
    .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready),
    .xfer_ch    (xfer_ch),
    .xfer_dir   (xfer_dir),
    .xfer_size  (xfer_size)
  );

  // R2: trigger bit is never stored, so it reads as zero
  assign rd_data = {1'b0, mode[rd_ch]};
endmodule

// File: tb/tb_dma_start_ctrl.sv
module tb_dma_start_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [0:0]  cfg_ch = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [0:0]  rd_ch = '0;
  logic [7:0]  rd_data;
  logic [1:0]  ch_enable = '0;
  logic [1:0]  ch_active = '0;
  logic [15:0] hw_req = '0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b1;
  logic [0:0]  xfer_ch;
  logic        xfer_dir, xfer_size;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dma_start_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch),
    .cfg_wdata(cfg_wdata), .rd_ch(rd_ch), .rd_data(rd_data),
    .ch_enable(ch_enable), .ch_active(ch_active), .hw_req(hw_req),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_ch(xfer_ch),
    .xfer_dir(xfer_dir), .xfer_size(xfer_size)
  );

  // {ch, mode, enable, kind(0 sw,1 hw), line, expect}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 8'h03, 1'b1, 1'b0, 4'd0,  1'b1},
    {1'b0, 8'h45, 1'b1, 1'b1, 4'd5,  1'b1},
    {1'b1, 8'h2A, 1'b1, 1'b1, 4'd10, 1'b1},
    {1'b1, 8'h6F, 1'b0, 1'b0, 4'd0,  1'b0},
    {1'b0, 8'h07, 1'b1, 1'b1, 4'd8,  1'b0},
    {1'b1, 8'h60, 1'b1, 1'b0, 4'd0,  1'b1},
    {1'b0, 8'h2C, 1'b0, 1'b1, 4'd12, 1'b0},
    {1'b1, 8'h4E, 1'b1, 1'b1, 4'd14, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ch = ch; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(xfer_valid == 1'b0, tag, xfer_valid, 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_ch = 1'b0; #1 chk(rd_data == 8'h00, "R1 ch0 mode", rd_data, 0);
    rd_ch = 1'b1; #1 chk(rd_data == 8'h00, "R1 ch1 mode", rd_data, 0);
    chk(xfer_valid == 1'b0, "R1 valid", xfer_valid, 0);

    // table-driven: R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      logic       ch;
      logic [7:0] md;
      logic       en, kind, ex;
      logic [3:0] ln;
      {ch, md, en, kind, ln, ex} = VEC[v];
      ch_enable = '0;
      ch_enable[ch] = en;
      wr(ch, md);
      rd_ch = ch; #1
      chk(rd_data == {1'b0, md[6:0]}, "R2 readback", rd_data, {1'b0, md[6:0]});
      @(negedge clk);
      if (kind) hw_req[ln] = 1'b1;
      else begin cfg_wr = 1'b1; cfg_ch = ch; cfg_wdata = md | 8'h80; end
      @(negedge clk);
      cfg_wr = 1'b0;
      chk(xfer_valid == 1'b0, "R3 R4 latency early", xfer_valid, 0);
      @(negedge clk);
      chk(xfer_valid == ex, kind ? "R4 hw start" : "R3 sw start", xfer_valid, ex);
      if (ex) begin
        chk(xfer_ch == ch, "R5 channel", xfer_ch, ch);
        chk(xfer_dir == md[6], "R5 direction", xfer_dir, md[6]);
        chk(xfer_size == md[5], "R5 width", xfer_size, md[5]);
      end
      #1 chk(rd_data[7] == 1'b0, "R2 trigger reads 0", rd_data[7], 0);
      quiet(4, "R4 no retrigger");
      hw_req = '0;
      @(negedge clk);
    end

    // R6: hold aging, request in first clock after write launches
    ch_enable = 2'b01;
    wr(1'b0, 8'h01);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ch = 1'b0; cfg_wdata = 8'h11;
    @(negedge clk);
    cfg_wr = 1'b0; hw_req[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(xfer_valid == 1'b1, "R6 first clock launches", xfer_valid, 1);
    hw_req = '0;
    wr(1'b0, 8'h01);
    // R6: second clock still launches
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'h11;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    hw_req[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(xfer_valid == 1'b1, "R6 second clock launches", xfer_valid, 1);
    hw_req = '0;
    wr(1'b0, 8'h01);
    // R6: third clock is parked
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'h11;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    hw_req[1] = 1'b1;
    quiet(5, "R6 third clock parked");
    hw_req = '0;
    @(negedge clk);
    hw_req[1] = 1'b1;   // R8 second request while parked
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'h91;  // trigger, hold kept
    @(negedge clk);
    cfg_wr = 1'b0;
    quiet(3, "R8 still parked");
    // R7 release
    cfg_wr = 1'b1; cfg_wdata = 8'h01;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    chk(xfer_valid == 1'b0, "R7 release early", xfer_valid, 0);
    @(negedge clk);
    chk(xfer_valid == 1'b1, "R7 release launch", xfer_valid, 1);
    quiet(5, "R8 merged to one");
    hw_req = '0;

    // R8: trigger and hw edge in the same cycle
    wr(1'b0, 8'h06);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 8'h86; hw_req[6] = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    chk(xfer_valid == 1'b1, "R8 coincident launch", xfer_valid, 1);
    quiet(4, "R8 coincident single");
    hw_req = '0;

    // R9: write protection while active
    ch_enable = 2'b10;
    wr(1'b1, 8'h00);
    ch_active = 2'b10;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ch = 1'b1; cfg_wdata = 8'hFF;
    @(negedge clk);
    cfg_wr = 1'b0;
    rd_ch = 1'b1; #1
    chk(rd_data == 8'h10, "R9 only hold written", rd_data, 8'h10);
    @(negedge clk);
    chk(xfer_valid == 1'b1, "R9 trigger while active", xfer_valid, 1);
    chk(xfer_dir == 1'b0 && xfer_size == 1'b0, "R9 attrs unchanged",
        {xfer_dir, xfer_size}, 0);
    @(negedge clk);
    wr(1'b1, 8'h60);
    #1 chk(rd_data == 8'h00, "R9 fields ignored", rd_data, 0);
    ch_active = '0;
    wr(1'b1, 8'h60);
    #1 chk(rd_data == 8'h60, "R9 writable when idle", rd_data, 8'h60);

    // R10 R11: both channels on one line, port stalled
    ch_enable = 2'b11;
    wr(1'b0, 8'h04);
    wr(1'b1, 8'h64);
    xfer_ready = 1'b0;
    @(negedge clk);
    hw_req[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(xfer_valid == 1'b1 && xfer_ch == 1'b0, "R10 ch0 first",
        {xfer_valid, xfer_ch}, 2'b10);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(xfer_valid == 1'b1 && xfer_ch == 1'b0 && xfer_dir == 1'b0,
          "R11 stalled stable", {xfer_valid, xfer_ch, xfer_dir}, 3'b100);
    end
    xfer_ready = 1'b1;
    @(negedge clk);
    chk(xfer_valid == 1'b0, "R10 gap after handshake", xfer_valid, 0);
    @(negedge clk);
    chk(xfer_valid == 1'b1 && xfer_ch == 1'b1, "R10 ch1 second",
        {xfer_valid, xfer_ch}, 2'b11);
    chk(xfer_dir == 1'b1 && xfer_size == 1'b1, "R5 ch1 attrs",
        {xfer_dir, xfer_size}, 2'b11);
    quiet(3, "R10 no extra");
    hw_req = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule